// File: doc/BRIEF.md
# Memory protection region checker

This block decides, for every memory access presented to it, whether the access may proceed. It holds no configuration of its own: a separate register block drives a bank of protection regions into it as parallel vectors (base, size code, subregion-disable mask, permission code, execute-never bit and enable bit for each region), together with three global control bits. Each access carries an address and four qualifiers: privileged, write, instruction fetch, and "running in a hard-fault, NMI or fault-masked handler".

A region covers 2^(size+1) bytes on a naturally aligned base. Only address bits above the region size are compared with the base. Regions of 256 bytes or more are split into eight equal slices, and any slice can be masked out. When several enabled regions cover the address, the highest-numbered one decides. A three-bit code selects the read/write rights for privileged and unprivileged accesses, and an execute-never bit blocks instruction fetches. The verdict, a hit flag and the index of the deciding region are registered and appear one clock after the request.

Top module: `prot_region_chk`

## Requirements
- R1: A region with size code S (4 to 31) matches an address exactly when the address bits at and above position S+1 equal those bits of its base; base bits below S+1 are ignored.
- R2: A region whose size code is below 4 never matches.
- R3: For size codes of 7 or more, address bits [S:S-2] select one of eight slices and a 1 in that bit of the region's 8-bit mask stops the region matching there; for size codes below 7 the mask has no effect.
- R4: Permission codes grant: 0 nothing; 1 privileged read/write only; 2 privileged read/write plus unprivileged read; 3 read/write for everyone; 5 privileged read only; 6 read only for everyone; 4 and 7 nothing. An instruction fetch counts as a read.
- R5: An instruction fetch that lands on a deciding region with its execute-never bit set is refused, whatever its permission code.
- R6: A region whose enable bit is 0 never matches.
- R7: With the global enable at 0, every access is allowed and reports no hit and region 0.
- R8: With the background control bit at 1, a privileged access that matches no region is allowed; unprivileged accesses and accesses that do match a region are unaffected by it.
- R9: With the handler-check bit at 0, an access flagged as made from a hard-fault, NMI or fault-masked handler is allowed and reports no hit; with the bit at 1 it is checked normally.
- R10: When several enabled regions match, the highest-numbered one is reported and its permission and execute-never settings decide.
- R11: With the global enable at 1, an access that is checked, matches no region and has no background region available is refused; a no-hit result always reports region 0.
- R12: The response valid, allow, hit and region outputs are registered: they reflect the request of the previous clock, are all 0 after a synchronous active-low reset, and allow, hit and region are 0 in any cycle where the response is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_enable | input | 1 | Global checking enable |
| ctl_bg_priv | input | 1 | Allow unmatched privileged accesses |
| ctl_handler_chk | input | 1 | Check accesses from fault/NMI handlers |
| cfg_en | input | NUM_REGIONS | Per-region enable |
| cfg_xn | input | NUM_REGIONS | Per-region execute-never |
| cfg_perm | input | NUM_REGIONS*3 | Per-region permission code |
| cfg_size | input | NUM_REGIONS*5 | Per-region size code |
| cfg_srd | input | NUM_REGIONS*8 | Per-region slice-disable mask |
| cfg_base | input | NUM_REGIONS*ADDR_W | Per-region base address |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access address |
| req_priv | input | 1 | Access is privileged |
| req_write | input | 1 | Access is a data write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_handler | input | 1 | Access made from a fault/NMI handler |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access allowed |
| rsp_hit | output | 1 | Some enabled region matched |
| rsp_region | output | IDX_W | Index of deciding region |

## Verification
The properties assume that the configuration vectors and control bits hold steady across the clock that turns a request into its response, and that an instruction fetch never also carries the write flag. The stimulus changes configuration only between requests and keeps write low on every fetch. Region bases are always chosen aligned to their size, so the R1 vectors probe region edges without depending on how misaligned base bits are treated.

// File: rtl/prot_pkg.sv
// Shared constants and the permission-code encoding for the
// protection region checker. Assumes 3-bit permission codes,
// 5-bit size codes and 8-slice masks.
package prot_pkg;

    localparam int SIZE_W          = 5;
    localparam int SRD_W           = 8;
    localparam int PERM_W          = 3;
    localparam int MIN_SIZE_CODE   = 4;  // smallest legal size code (32 bytes)
    localparam int SLICE_MIN_CODE  = 7;  // slices apply from 256 bytes up

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE        = 3'd0,
        PERM_PRIV_RW     = 3'd1,
        PERM_PRIV_RW_URD = 3'd2,
        PERM_ALL_RW      = 3'd3,
        PERM_RSVD4       = 3'd4,
        PERM_PRIV_RD     = 3'd5,
        PERM_ALL_RD      = 3'd6,
        PERM_RSVD7       = 3'd7
    } perm_code_e;

endpackage

// File: rtl/prot_region_match.sv
// Address match for one protection region.
// Compares the address bits above the region size with the base,
// then applies the eight-slice disable mask for regions of 256 bytes
// or larger. Assumes the base is aligned to the region size; lower
// base bits are ignored. Reserved size codes never match.
module prot_region_match
    import prot_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [SRD_W-1:0]  srd_i,
    input  logic              en_i,
    output logic              hit_o
);

    logic [5:0]        top_sh;
    logic [SIZE_W-1:0] slice_sh;
    logic [ADDR_W-1:0] cmp_mask;
    logic [2:0]        slice_idx;
    logic              base_ok;
    logic              slice_ok;
    logic              size_ok;

    // Decode size into a compare mask and a slice index, then combine.
    always_comb begin
        top_sh    = {1'b0, size_i} + 6'd1;
        cmp_mask  = {ADDR_W{1'b1}} << top_sh;
        base_ok   = ((addr_i ^ base_i) & cmp_mask) == '0;
        slice_sh  = size_i - SIZE_W'(2);
        slice_idx = 3'(addr_i >> slice_sh);
        size_ok   = size_i >= SIZE_W'(MIN_SIZE_CODE);
        slice_ok  = (size_i < SIZE_W'(SLICE_MIN_CODE)) || !srd_i[slice_idx];
        hit_o     = en_i && size_ok && base_ok && slice_ok;
    end

endmodule

// File: rtl/prot_pick_top.sv
// Priority picker: reports whether any hit bit is set and the index of
// the highest-numbered set bit. Assumes NUM >= 1.
module prot_pick_top #(
    parameter int NUM   = 8,
    parameter int IDX_W = (NUM < 2) ? 1 : $clog2(NUM)
) (
    input  logic [NUM-1:0]   hits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Ascending scan so the last (highest) set bit wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NUM; i++) begin
            if (hits_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prot_perm_eval.sv
// Permission evaluation for the deciding region.
// Maps the 3-bit permission code, privilege and write flags to a
// read/write grant, then blocks fetches from execute-never regions.
// Assumes a fetch is presented with the write flag low.
module prot_perm_eval
    import prot_pkg::*;
(
    input  logic [PERM_W-1:0] perm_i,
    input  logic              xn_i,
    input  logic              priv_i,
    input  logic              write_i,
    input  logic              fetch_i,
    output logic              ok_o
);

    logic rw_ok;

    // Permission table; reserved codes grant nothing.
    always_comb begin
        case (perm_code_e'(perm_i))
            PERM_NONE:        rw_ok = 1'b0;
            PERM_PRIV_RW:     rw_ok = priv_i;
            PERM_PRIV_RW_URD: rw_ok = priv_i || !write_i;
            PERM_ALL_RW:      rw_ok = 1'b1;
            PERM_PRIV_RD:     rw_ok = priv_i && !write_i;
            PERM_ALL_RD:      rw_ok = !write_i;
            default:          rw_ok = 1'b0;
        endcase
        ok_o = rw_ok && !(xn_i && fetch_i);
    end

endmodule

// File: rtl/prot_region_chk.sv
// Protection region checker top.
// Matches each request against NUM_REGIONS regions in parallel, picks
// the highest-numbered hit, evaluates its rights, applies the global
// enable, handler bypass and privileged background rules, and
// registers the verdict one cycle later. Configuration arrives as flat
// vectors, region i in slice i; it is assumed stable around requests.
module prot_region_chk
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = (NUM_REGIONS < 2) ? 1 : $clog2(NUM_REGIONS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_enable,
    input  logic                          ctl_bg_priv,
    input  logic                          ctl_handler_chk,
    input  logic [NUM_REGIONS-1:0]        cfg_en,
    input  logic [NUM_REGIONS-1:0]        cfg_xn,
    input  logic [NUM_REGIONS*PERM_W-1:0] cfg_perm,
    input  logic [NUM_REGIONS*SIZE_W-1:0] cfg_size,
    input  logic [NUM_REGIONS*SRD_W-1:0]  cfg_srd,
    input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_base,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic                          req_priv,
    input  logic                          req_write,
    input  logic                          req_fetch,
    input  logic                          req_handler,
    output logic                          rsp_valid,
    output logic                          rsp_allow,
    output logic                          rsp_hit,
    output logic [IDX_W-1:0]              rsp_region
);

    logic [NUM_REGIONS-1:0] hits;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic [PERM_W-1:0]      win_perm;
    logic                   win_xn;
    logic                   win_ok;
    logic                   bypass;
    logic                   allow_c;
    logic                   hit_c;
    logic [IDX_W-1:0]       region_c;

    // One matcher per region.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        prot_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .addr_i (req_addr),
            .base_i (cfg_base[g*ADDR_W +: ADDR_W]),
            .size_i (cfg_size[g*SIZE_W +: SIZE_W]),
            .srd_i  (cfg_srd[g*SRD_W +: SRD_W]),
            .en_i   (cfg_en[g]),
            .hit_o  (hits[g])
        );
    end

    prot_pick_top #(
        .NUM   (NUM_REGIONS),
        .IDX_W (IDX_W)
    ) u_pick (
        .hits_i (hits),
        .any_o  (any_hit),
        .idx_o  (win_idx)
    );

    // Select the deciding region's rights.
    always_comb begin
        win_perm = cfg_perm[win_idx*PERM_W +: PERM_W];
        win_xn   = cfg_xn[win_idx];
    end

    prot_perm_eval u_perm (
        .perm_i  (win_perm),
        .xn_i    (win_xn),
        .priv_i  (req_priv),
        .write_i (req_write),
        .fetch_i (req_fetch),
        .ok_o    (win_ok)
    );

    // Combine global control rules into the next verdict.
    always_comb begin
        bypass = !ctl_enable || (req_handler && !ctl_handler_chk);
        if (bypass) begin
            allow_c  = 1'b1;
            hit_c    = 1'b0;
            region_c = '0;
        end else if (any_hit) begin
            allow_c  = win_ok;
            hit_c    = 1'b1;
            region_c = win_idx;
        end else begin
            allow_c  = req_priv && ctl_bg_priv;
            hit_c    = 1'b0;
            region_c = '0;
        end
    end

    // Register the response; results are zero when no request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_region <= '0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_allow  <= req_valid && allow_c;
            rsp_hit    <= req_valid && hit_c;
            rsp_region <= req_valid ? region_c : '0;
        end
    end

endmodule

// File: rtl/prot_region_chk_sva.sv
// Assertion checker for prot_region_chk, attached by bind.
// Holds one-cycle copies of the inputs so each response can be
// related to the request that produced it.
module prot_region_chk_sva #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W      = (NUM_REGIONS < 2) ? 1 : $clog2(NUM_REGIONS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ctl_enable,
    input logic                   ctl_bg_priv,
    input logic                   ctl_handler_chk,
    input logic [NUM_REGIONS-1:0] cfg_en,
    input logic [NUM_REGIONS-1:0] cfg_xn,
    input logic                   req_valid,
    input logic                   req_priv,
    input logic                   req_fetch,
    input logic                   req_handler,
    input logic                   rsp_valid,
    input logic                   rsp_allow,
    input logic                   rsp_hit,
    input logic [IDX_W-1:0]       rsp_region
);

    logic [NUM_REGIONS-1:0] en_q;
    logic [NUM_REGIONS-1:0] xn_q;
    logic                   fetch_q, priv_q, hdl_q, gen_q, bg_q, hchk_q;

    // Capture the previous cycle's request and configuration.
    always_ff @(posedge clk) begin
        en_q    <= cfg_en;
        xn_q    <= cfg_xn;
        fetch_q <= req_fetch;
        priv_q  <= req_priv;
        hdl_q   <= req_handler;
        gen_q   <= ctl_enable;
        bg_q    <= ctl_bg_priv;
        hchk_q  <= ctl_handler_chk;
    end

    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && !rsp_hit && rsp_region == '0));
    assert_disabled_allows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ctl_enable) |=> (rsp_allow && !rsp_hit));
    assert_handler_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_handler && !ctl_handler_chk) |=> (rsp_allow && !rsp_hit));
    assert_hit_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> en_q[rsp_region]);
    assert_xn_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && fetch_q && xn_q[rsp_region]) |-> !rsp_allow);
    assert_nomatch_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && rsp_allow) |-> (!gen_q || (hdl_q && !hchk_q) || (priv_q && bg_q)));
    assert_nomatch_region_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_region == '0));

endmodule

bind prot_region_chk prot_region_chk_sva #(.NUM_REGIONS(NUM_REGIONS)) u_sva (.*);

// File: tb/sim_prot_region_chk.sv
`timescale 1ns/1ps
module sim_prot_region_chk;

    localparam int NR = 8;
    localparam int AW = 32;

    typedef struct packed {
        logic [31:0] addr;
        logic        priv;
        logic        wr;
        logic        fetch;
        logic        hdl;
        logic [2:0]  ctl;   // {enable, background, handler_check}
        logic        allow;
        logic        hit;
        logic [2:0]  rgn;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{32'h0800_1234, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd0, 8'd1},  // R1 inside
        '{32'h080F_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 3'b101, 1'b1, 1'b1, 3'd0, 8'd1},  // R1 top edge
        '{32'h0810_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b0, 3'd0, 8'd11}, // R11 just past
        '{32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd1, 8'd4},  // R4 code 2 user read
        '{32'h2000_0010, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd1, 8'd4},  // R4 code 2 user write
        '{32'h2000_0010, 1'b1, 1'b0, 1'b1, 1'b0, 3'b101, 1'b0, 1'b1, 3'd1, 8'd5},  // R5 xn fetch
        '{32'h2000_4100, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd4, 8'd10}, // R10 overlap
        '{32'h2000_4100, 1'b1, 1'b1, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd4, 8'd4},  // R4 code 5 priv write
        '{32'h2000_4100, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd4, 8'd10}, // R10 upper decides
        '{32'h2000_4100, 1'b1, 1'b0, 1'b1, 1'b0, 3'b101, 1'b1, 1'b1, 3'd4, 8'd5},  // R5 winner not xn
        '{32'h4002_0100, 1'b1, 1'b1, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd2, 8'd4},  // R4 code 1 priv
        '{32'h4002_0100, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd2, 8'd4},  // R4 code 1 user
        '{32'h4002_2100, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd3, 8'd4},  // R4 code 6 read
        '{32'h4002_2100, 1'b1, 1'b1, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd3, 8'd4},  // R4 code 6 write
        '{32'h4002_2C00, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b0, 3'd0, 8'd3},  // R3 slice 6 off
        '{32'h4002_2BFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd3, 8'd3},  // R3 slice 5 on
        '{32'h6000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b0, 3'd0, 8'd2},  // R2 reserved size
        '{32'h7000_0010, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b0, 3'd0, 8'd6},  // R6 disabled
        '{32'h3000_0070, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd7, 8'd3},  // R3 mask ignored, code 4
        '{32'h3000_0080, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b0, 3'd0, 8'd1},  // R1 128B edge
        '{32'h0810_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b111, 1'b1, 1'b0, 3'd0, 8'd8},  // R8 priv bg
        '{32'h0810_0000, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111, 1'b0, 1'b0, 3'd0, 8'd8},  // R8 user no bg
        '{32'h2000_4100, 1'b0, 1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 1'b1, 3'd4, 8'd8},  // R8 match wins
        '{32'h2000_0010, 1'b0, 1'b1, 1'b0, 1'b1, 3'b100, 1'b1, 1'b0, 3'd0, 8'd9},  // R9 bypass
        '{32'h2000_0010, 1'b0, 1'b1, 1'b0, 1'b1, 3'b101, 1'b0, 1'b1, 3'd1, 8'd9},  // R9 checked
        '{32'h2000_0010, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0, 3'd0, 8'd7},  // R7 off
        '{32'h6000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 3'b011, 1'b1, 1'b0, 3'd0, 8'd7}   // R7 off
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ctl_enable, ctl_bg_priv, ctl_handler_chk;
    logic [NR-1:0]     cfg_en, cfg_xn;
    logic [NR*3-1:0]   cfg_perm;
    logic [NR*5-1:0]   cfg_size;
    logic [NR*8-1:0]   cfg_srd;
    logic [NR*AW-1:0]  cfg_base;
    logic              req_valid, req_priv, req_write, req_fetch, req_handler;
    logic [AW-1:0]     req_addr;
    logic              rsp_valid, rsp_allow, rsp_hit;
    logic [2:0]        rsp_region;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    prot_region_chk #(.NUM_REGIONS(NR), .ADDR_W(AW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_region(input int i, input logic [31:0] base, input logic [4:0] sz,
                              input logic [7:0] srd, input logic [2:0] perm,
                              input logic xn, input logic en);
        cfg_base[i*AW +: AW] = base;
        cfg_size[i*5 +: 5]   = sz;
        cfg_srd[i*8 +: 8]    = srd;
        cfg_perm[i*3 +: 3]   = perm;
        cfg_xn[i]            = xn;
        cfg_en[i]            = en;
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = v.addr;
        req_priv    = v.priv;
        req_write   = v.wr;
        req_fetch   = v.fetch;
        req_handler = v.hdl;
        {ctl_enable, ctl_bg_priv, ctl_handler_chk} = v.ctl;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {ctl_enable, ctl_bg_priv, ctl_handler_chk} = 3'b101;
        cfg_en = '0; cfg_xn = '0; cfg_perm = '0; cfg_size = '0; cfg_srd = '0; cfg_base = '0;
        set_region(0, 32'h0800_0000, 5'h13, 8'h00, 3'd3, 1'b0, 1'b1);
        set_region(1, 32'h2000_0000, 5'h0E, 8'h00, 3'd2, 1'b1, 1'b1);
        set_region(2, 32'h4002_0000, 5'h0C, 8'h00, 3'd1, 1'b1, 1'b1);
        set_region(3, 32'h4002_2000, 5'h0B, 8'hC0, 3'd6, 1'b1, 1'b1);
        set_region(4, 32'h2000_4000, 5'h0D, 8'h00, 3'd5, 1'b0, 1'b1);
        set_region(5, 32'h6000_0000, 5'h03, 8'h00, 3'd3, 1'b0, 1'b1);
        set_region(6, 32'h7000_0000, 5'h0A, 8'h00, 3'd3, 1'b0, 1'b0);
        set_region(7, 32'h3000_0000, 5'h06, 8'hFF, 3'd4, 1'b0, 1'b1);
        // Request held high through reset: outputs must stay zero (R12).
        req_valid = 1'b1; req_addr = 32'h0800_0000;
        req_priv = 1'b1; req_write = 1'b0; req_fetch = 1'b0; req_handler = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R12 reset valid", 32'(rsp_valid), 32'd0);
        check("R12 reset allow", 32'(rsp_allow), 32'd0);
        check("R12 reset hit", 32'(rsp_hit), 32'd0);
        check("R12 reset region", 32'(rsp_region), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        check("R12 idle valid", 32'(rsp_valid), 32'd0);
        check("R12 idle allow", 32'(rsp_allow), 32'd0);

        // Vector table.
        for (int k = 0; k < NV; k++) begin
            drive(VECS[k]);
            check($sformatf("R%0d vec%0d valid", VECS[k].tag, k), 32'(rsp_valid), 32'd1);
            check($sformatf("R%0d vec%0d allow", VECS[k].tag, k), 32'(rsp_allow), 32'(VECS[k].allow));
            check($sformatf("R%0d vec%0d hit", VECS[k].tag, k), 32'(rsp_hit), 32'(VECS[k].hit));
            check($sformatf("R%0d vec%0d region", VECS[k].tag, k), 32'(rsp_region), 32'(VECS[k].rgn));
        end

        // R12 latency: allowed access, then a refused one; output lags a clock.
        drive('{32'h0800_0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd0, 8'd12});
        @(negedge clk);
        req_addr = 32'h0810_0000;
        #2;
        check("R12 before edge allow", 32'(rsp_allow), 32'd1);
        @(posedge clk); #1;
        check("R12 after edge allow", 32'(rsp_allow), 32'd0);

        // R4 reserved and zero codes on region 7, then code 3 to prove the match.
        @(negedge clk); req_valid = 1'b0; cfg_perm[7*3 +: 3] = 3'd0;
        drive('{32'h3000_0070, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd7, 8'd4});
        check("R4 code 0 allow", 32'(rsp_allow), 32'd0);
        @(negedge clk); req_valid = 1'b0; cfg_perm[7*3 +: 3] = 3'd7;
        drive('{32'h3000_0070, 1'b1, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 1'b1, 3'd7, 8'd4});
        check("R4 code 7 allow", 32'(rsp_allow), 32'd0);
        @(negedge clk); req_valid = 1'b0; cfg_perm[7*3 +: 3] = 3'd3;
        drive('{32'h3000_0070, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd7, 8'd4});
        check("R4 code 3 allow", 32'(rsp_allow), 32'd1);
        check("R3 small region hit", 32'(rsp_hit), 32'd1);

        // R6: enabling region 6 makes it match.
        @(negedge clk); req_valid = 1'b0; cfg_en[6] = 1'b1;
        drive('{32'h7000_0010, 1'b0, 1'b1, 1'b0, 1'b0, 3'b101, 1'b1, 1'b1, 3'd6, 8'd6});
        check("R6 enabled hit", 32'(rsp_hit), 32'd1);
        check("R6 enabled region", 32'(rsp_region), 32'd6);

        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check("R12 drop valid", 32'(rsp_valid), 32'd0);
        check("R12 drop hit", 32'(rsp_hit), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule